// File: doc/BRIEF.md
# Xon/Xoff In-Band Flow Controller

This block adds character-based (in-band) flow control to one serial channel. On the receive side it watches the fill level of the receive FIFO. When the level climbs to a programmed halt threshold, it asks the serializer to send the stop character. When the level drains back to a lower resume threshold, it asks for the go character. The gap between the two thresholds gives hysteresis, so each crossing produces exactly one control character.

On the transmit side it screens every character the deserializer delivers. A match against the programmed stop or go value is consumed as a control token and does not reach the FIFO. The match suspends or releases the local transmitter. An optional mode lets any other received character release a suspended transmitter as well.

Thresholds are programmed as 4-bit step counts and scaled by four, so a step value of 15 means a level of 60 and a step value of 8 means a level of 32. A control character waiting to be sent always goes ahead of the next FIFO data character.

Top module: `swfc_ctrl`

## Requirements
- R1: With `sw_en` high and no stop outstanding, a `rx_level` of at least `halt_step`*4 raises `inj_req` on the next clock, with `inj_char` equal to `xoff_char`.
- R2: After a stop has been requested, a `rx_level` at or below `resume_step`*4 raises `inj_req` on the next clock, with `inj_char` equal to `xon_char`.
- R3: Only one stop character is requested per upward crossing and one go character per downward crossing. Levels that stay above the halt threshold, including the extra character arriving while the stop is being sent, request nothing more.
- R4: `inj_req` stays high with its character until a clock at which `inj_ack` is high, and it is low on the following clock. A new event before the acknowledge replaces the pending character with the newer one.
- R5: With `sw_en` high, a received character equal to `xoff_char` sets `tx_hold` on the next clock, and one equal to `xon_char` clears it. In the same cycle `rx_wr_en` is held low for either match. If both values are equal, the stop meaning wins.
- R6: Any other received character is passed through in the same cycle (`rx_wr_en` = `rx_valid`, `rx_wr_data` = `rx_char`). It clears `tx_hold` on the next clock when `any_resume` is 1, and leaves `tx_hold` unchanged when `any_resume` is 0.
- R7: `tx_data_ok` is high exactly when `tx_hold` is low and no injection is pending. A pending control character is never blocked by `tx_hold`.
- R8: With `sw_en` low, nothing is filtered, and on the next clock `inj_req` and `tx_hold` are low. Any pending request and any halt state are dropped.
- R9: While reset is asserted, `inj_req` and `tx_hold` are low and `tx_data_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sw_en | input | 1 | Enables software flow control |
| any_resume | input | 1 | When 1, any received non-control character releases the transmitter |
| xon_char | input | 8 | Programmed go character |
| xoff_char | input | 8 | Programmed stop character |
| halt_step | input | 4 | Halt threshold in units of 4 FIFO entries |
| resume_step | input | 4 | Resume threshold in units of 4 FIFO entries |
| rx_level | input | 7 | Current receive FIFO fill level (0 to 64) |
| rx_valid | input | 1 | Strobe: a received character is present on `rx_char` |
| rx_char | input | 8 | Received character from the deserializer |
| rx_wr_en | output | 1 | Write strobe to the receive FIFO (control tokens removed) |
| rx_wr_data | output | 8 | Data to the receive FIFO |
| inj_req | output | 1 | Request to the serializer to send `inj_char` next |
| inj_char | output | 8 | Control character to inject |
| inj_ack | input | 1 | Serializer has taken the injected character |
| tx_hold | output | 1 | Transmitter suspended by a received stop character |
| tx_data_ok | output | 1 | Serializer may start the next FIFO data character |

## Verification
The level side is swept over every halt/resume step pair with halt above resume. Each pair gets a full ramp of the FIFO level from empty to 64 and back. This separates the two comparison directions and catches off-by-one threshold scaling and repeated requests. A run with the acknowledge held off shows that a request is held and then replaced by a newer event. The screening side is fed all 256 character values, with the resume-on-any option off and then on. This shows which values are filtered and which change the hold state. Disabling the feature while a request and a hold are pending shows that both are dropped and that nothing is filtered.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef enum logic {
    CTL_XON  = 1'b0,
    CTL_XOFF = 1'b1
  } ctl_kind_e;
endpackage

// File: rtl/swfc_level_mon.sv
module swfc_level_mon #(
  parameter int LEVEL_W    = 7,
  parameter int STEP_W     = 4,
  parameter int STEP_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_en,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic [STEP_W-1:0]  halt_step,
  input  logic [STEP_W-1:0]  resume_step,
  output logic               ev_xoff,
  output logic               ev_xon
);
  localparam int THR_W = STEP_W + STEP_SHIFT;
  localparam int CMP_W = (THR_W > LEVEL_W) ? THR_W : LEVEL_W;

  logic [CMP_W-1:0] lvl_x;
  logic [CMP_W-1:0] halt_x;
  logic [CMP_W-1:0] resume_x;
  logic             stopped_q;
  logic             stopped_d;

  assign lvl_x    = CMP_W'(rx_level);
  assign halt_x   = CMP_W'({halt_step, {STEP_SHIFT{1'b0}}});
  assign resume_x = CMP_W'({resume_step, {STEP_SHIFT{1'b0}}});

  always_comb begin
    ev_xoff   = sw_en && !stopped_q && (lvl_x >= halt_x);
    ev_xon    = sw_en &&  stopped_q && (lvl_x <= resume_x);
    stopped_d = stopped_q;
    if (!sw_en) begin
      stopped_d = 1'b0;
    end else if (ev_xoff) begin
      stopped_d = 1'b1;
    end else if (ev_xon) begin
      stopped_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q <= 1'b0;
    end else begin
      stopped_q <= stopped_d;
    end
  end

  // halt state is only entered after the level really reached the halt threshold
  p_halt_needs_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped_q) |-> $past(lvl_x >= halt_x));

  // leaving the halt state needs the level at or below the resume threshold, or the feature off
  p_resume_needs_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stopped_q) |-> $past((lvl_x <= resume_x) || !sw_en));
endmodule

// File: rtl/swfc_inject.sv
module swfc_inject
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic              ev_xoff,
  input  logic              ev_xon,
  input  logic              inj_ack,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  output logic              inj_req,
  output logic [CHAR_W-1:0] inj_char
);
  logic      pend_q;
  logic      pend_d;
  ctl_kind_e kind_q;
  ctl_kind_e kind_d;

  always_comb begin
    pend_d = pend_q;
    kind_d = kind_q;
    if (!sw_en) begin
      pend_d = 1'b0;
    end else if (ev_xoff) begin
      pend_d = 1'b1;
      kind_d = CTL_XOFF;
    end else if (ev_xon) begin
      pend_d = 1'b1;
      kind_d = CTL_XON;
    end else if (inj_ack) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= CTL_XON;
    end else begin
      pend_q <= pend_d;
      kind_q <= kind_d;
    end
  end

  assign inj_req  = pend_q;
  assign inj_char = (kind_q == CTL_XOFF) ? xoff_char : xon_char;

  p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_req && !inj_ack && sw_en) |=> inj_req);

  p_xoff_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_req && inj_ack && (kind_q == CTL_XOFF)) |=> !(inj_req && (kind_q == CTL_XOFF)));

  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> !inj_req);
endmodule

// File: rtl/swfc_rx_screen.sv
module swfc_rx_screen #(
  parameter int CHAR_W = 8
) (
  input  logic              sw_en,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  output logic              hit_xoff,
  output logic              hit_xon,
  output logic              hit_other,
  output logic              wr_en,
  output logic [CHAR_W-1:0] wr_data
);
  logic scan;

  always_comb begin
    scan      = rx_valid && sw_en;
    hit_xoff  = scan && (rx_char == xoff_char);
    hit_xon   = scan && !hit_xoff && (rx_char == xon_char);
    hit_other = scan && !hit_xoff && !hit_xon;
    wr_en     = rx_valid && !hit_xoff && !hit_xon;
    wr_data   = rx_char;
  end
endmodule

// File: rtl/swfc_tx_gate.sv
module swfc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_en,
  input  logic any_resume,
  input  logic hit_xoff,
  input  logic hit_xon,
  input  logic hit_other,
  output logic tx_hold
);
  logic hold_q;
  logic hold_d;

  always_comb begin
    hold_d = hold_q;
    if (!sw_en) begin
      hold_d = 1'b0;
    end else if (hit_xoff) begin
      hold_d = 1'b1;
    end else if (hit_xon || (hit_other && any_resume)) begin
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign tx_hold = hold_q;

  p_xoff_sets_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_xoff |=> tx_hold);

  p_other_keeps_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_other && !any_resume && sw_en) |=> (tx_hold == $past(tx_hold)));

  p_off_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> !tx_hold);
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl #(
  parameter int CHAR_W     = 8,
  parameter int FIFO_DEPTH = 64,
  parameter int STEP_W     = 4,
  parameter int STEP_SHIFT = 2,
  localparam int LEVEL_W   = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_en,
  input  logic               any_resume,
  input  logic [CHAR_W-1:0]  xon_char,
  input  logic [CHAR_W-1:0]  xoff_char,
  input  logic [STEP_W-1:0]  halt_step,
  input  logic [STEP_W-1:0]  resume_step,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic               rx_valid,
  input  logic [CHAR_W-1:0]  rx_char,
  output logic               rx_wr_en,
  output logic [CHAR_W-1:0]  rx_wr_data,
  output logic               inj_req,
  output logic [CHAR_W-1:0]  inj_char,
  input  logic               inj_ack,
  output logic               tx_hold,
  output logic               tx_data_ok
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  logic       ev_xoff;
  logic       ev_xon;
  logic       hit_xoff;
  logic       hit_xon;
  logic       hit_other;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  swfc_level_mon #(
    .LEVEL_W(LEVEL_W), .STEP_W(STEP_W), .STEP_SHIFT(STEP_SHIFT)
  ) level_mon_i (
    .clk(clk), .rst_n(rst_n_int), .sw_en(sw_en), .rx_level(rx_level),
    .halt_step(halt_step), .resume_step(resume_step),
    .ev_xoff(ev_xoff), .ev_xon(ev_xon)
  );

  swfc_inject #(.CHAR_W(CHAR_W)) inject_i (
    .clk(clk), .rst_n(rst_n_int), .sw_en(sw_en), .ev_xoff(ev_xoff),
    .ev_xon(ev_xon), .inj_ack(inj_ack), .xon_char(xon_char),
    .xoff_char(xoff_char), .inj_req(inj_req), .inj_char(inj_char)
  );

  swfc_rx_screen #(.CHAR_W(CHAR_W)) rx_screen_i (
    .sw_en(sw_en), .rx_valid(rx_valid), .rx_char(rx_char),
    .xon_char(xon_char), .xoff_char(xoff_char), .hit_xoff(hit_xoff),
    .hit_xon(hit_xon), .hit_other(hit_other), .wr_en(rx_wr_en),
    .wr_data(rx_wr_data)
  );

  swfc_tx_gate tx_gate_i (
    .clk(clk), .rst_n(rst_n_int), .sw_en(sw_en), .any_resume(any_resume),
    .hit_xoff(hit_xoff), .hit_xon(hit_xon), .hit_other(hit_other),
    .tx_hold(tx_hold)
  );

  assign tx_data_ok = !tx_hold && !inj_req;

  p_inject_beats_data_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(inj_req) |-> !tx_data_ok);
endmodule

// File: tb/swfc_ctrl_tb_top.sv
module swfc_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       sw_en;
  logic       any_resume;
  logic [7:0] xon_char;
  logic [7:0] xoff_char;
  logic [3:0] halt_step;
  logic [3:0] resume_step;
  logic [6:0] rx_level;
  logic       rx_valid;
  logic [7:0] rx_char;
  logic       rx_wr_en;
  logic [7:0] rx_wr_data;
  logic       inj_req;
  logic [7:0] inj_char;
  logic       inj_ack;
  logic       tx_hold;
  logic       tx_data_ok;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  logic m_stop, m_pend, m_kind, m_hold;

  swfc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .any_resume(any_resume),
    .xon_char(xon_char), .xoff_char(xoff_char), .halt_step(halt_step),
    .resume_step(resume_step), .rx_level(rx_level), .rx_valid(rx_valid),
    .rx_char(rx_char), .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
    .inj_req(inj_req), .inj_char(inj_char), .inj_ack(inj_ack),
    .tx_hold(tx_hold), .tx_data_ok(tx_data_ok)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // one cycle: drive at negedge, check filtering, clock, check registered outputs
  task automatic step(input logic [6:0] lvl, input logic v, input logic [7:0] ch,
                      input logic ack, input string tag);
    logic exp_wr;
    logic [7:0] exp_c;
    rx_level = lvl; rx_valid = v; rx_char = ch; inj_ack = ack;
    #1;
    exp_wr = v && !(sw_en && ((ch == xoff_char) || (ch == xon_char)));
    chk((rx_wr_en == exp_wr) && (!exp_wr || rx_wr_data == ch), {tag, " filter"},
        {23'd0, rx_wr_en, rx_wr_data}, {23'd0, exp_wr, ch});
    if (!sw_en) begin
      m_stop = 0; m_pend = 0; m_hold = 0;
    end else begin
      if (!m_stop && ({25'd0, lvl} >= 32'(halt_step) * 4)) begin
        m_stop = 1; m_pend = 1; m_kind = 1;
      end else if (m_stop && ({25'd0, lvl} <= 32'(resume_step) * 4)) begin
        m_stop = 0; m_pend = 1; m_kind = 0;
      end else if (ack) begin
        m_pend = 0;
      end
      if (v) begin
        if (ch == xoff_char) m_hold = 1;
        else if (ch == xon_char) m_hold = 0;
        else if (any_resume) m_hold = 0;
      end
    end
    @(negedge clk);
    exp_c = m_kind ? xoff_char : xon_char;
    chk((inj_req == m_pend) && (!m_pend || inj_char == exp_c) && (tx_hold == m_hold)
        && (tx_data_ok == (!m_hold && !m_pend)), {tag, " outputs"},
        {21'd0, inj_req, inj_char, tx_hold, tx_data_ok},
        {21'd0, m_pend, exp_c, m_hold, (!m_hold && !m_pend)});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        report();
      end
    end
  end

  initial begin
    rst_n = 0; sw_en = 1; any_resume = 0; xon_char = 8'h0D; xoff_char = 8'h0F;
    halt_step = 4'hF; resume_step = 4'h8; rx_level = 0; rx_valid = 0; rx_char = 0; inj_ack = 0;
    m_stop = 0; m_pend = 0; m_kind = 0; m_hold = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!inj_req && !tx_hold && tx_data_ok, "R9 reset", {29'd0, inj_req, tx_hold, tx_data_ok}, 32'd1);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R7: every halt/resume pair, full ramp up and down, prompt acknowledge
    for (int h = 1; h < 16; h++) begin
      for (int r = 0; r < h; r++) begin
        halt_step = 4'(h); resume_step = 4'(r);
        for (int l = 0; l <= 64; l++) step(7'(l), 1'b0, 8'h00, m_pend, "R1 R3 R7 ramp up");
        for (int l = 64; l >= 0; l--) step(7'(l), 1'b0, 8'h00, m_pend, "R2 R3 R7 ramp down");
      end
    end

    // R4: withheld acknowledge, then replacement by a newer event
    halt_step = 4'hF; resume_step = 4'h8;
    step(7'd60, 1'b0, 8'h00, 1'b0, "R4 xoff raised");
    for (int i = 0; i < 5; i++) step(7'd61, 1'b0, 8'h00, 1'b0, "R4 held without ack");
    step(7'd32, 1'b0, 8'h00, 1'b0, "R4 replaced by xon");
    step(7'd32, 1'b0, 8'h00, 1'b1, "R4 cleared after ack");
    step(7'd32, 1'b0, 8'h00, 1'b0, "R4 stays clear");

    // R5 R6: all character values, resume-on-any off then on
    for (int a = 0; a < 2; a++) begin
      any_resume = a[0];
      step(7'd0, 1'b1, 8'h0F, 1'b0, "R5 xoff first");
      for (int c = 0; c < 256; c++) step(7'd0, 1'b1, 8'(c), 1'b0, "R5 R6 char sweep");
      step(7'd0, 1'b1, 8'h0F, 1'b0, "R5 xoff again");
      step(7'd0, 1'b1, 8'h41, 1'b0, "R6 plain char");
      step(7'd0, 1'b0, 8'h0D, 1'b0, "R6 no strobe");
    end

    // R5: equal stop and go values, stop wins
    xon_char = 8'h33; xoff_char = 8'h33;
    step(7'd0, 1'b1, 8'h33, 1'b0, "R5 equal values");
    xon_char = 8'h0D; xoff_char = 8'h0F;
    step(7'd0, 1'b1, 8'h0D, 1'b0, "R5 xon releases");

    // R8: disable with a pending request and a hold
    any_resume = 0;
    step(7'd64, 1'b1, 8'h0F, 1'b0, "R8 setup");
    sw_en = 0;
    step(7'd64, 1'b1, 8'h0F, 1'b0, "R8 disabled");
    step(7'd64, 1'b1, 8'h0D, 1'b0, "R8 disabled no filter");
    step(7'd0, 1'b0, 8'h00, 1'b0, "R8 disabled quiet");
    sw_en = 1;
    step(7'd64, 1'b0, 8'h00, 1'b0, "R1 re-enabled");

    done = 1;
    report();
  end
endmodule